// File: doc/BRIEF.md
# Mixed-Decay Chopper Bridge Controller

This block drives the four gate enables of one H-bridge that feeds a single winding of a bipolar stepper motor. It counts pulses from a fast oscillator, and a fixed number of pulses makes one chopping period. Each period begins by driving current forward through the winding. When the external current-limit comparator trips, the bridge moves to slow decay, where both low-side switches recirculate the current. From a fixed count inside the period until the period ends, the bridge runs in fast decay, where it reverses and returns the stored energy to the supply.

The direction input swaps the roles of the two legs, so the winding current reverses while the mode order stays the same. The enable input blanks the gates without disturbing the period timing. A torque select picks one of two reference scale codes for the external reference DAC. An over-current flag shuts the bridge down and latches a fault. Only standby or reset clears that fault. Standby also blanks the gates and restarts chopping cleanly once it is released.

Top module: `mixed_decay_chopper`

## Requirements
- R1: After synchronous reset all four gates are 0, `fault_o` is 0 and `ref_code_o` holds the full-scale code (all ones).
- R2: The gate vector is written {hi1,hi2,lo1,lo2}. With `phase_i`=1, a period opens in charge with gates 1001, and charge is held while `limit_i` stays low, including past the slow-decay end count.
- R3: While in charge, a high `limit_i` moves the bridge to slow decay (gates 0011) at the next clock if the period count is below SLOW_END (default 6). Further limit pulses inside that period have no effect.
- R4: Slow decay becomes fast decay (gates 0110 with `phase_i`=1) when the count reaches SLOW_END. A limit that arrives at or after SLOW_END while in charge goes directly to fast decay.
- R5: One period lasts PERIOD_TICKS (default 8) `osc_tick_i` pulses. The count is 0 to PERIOD_TICKS-1. The pulse that wraps the count to 0 returns the bridge to charge.
- R6: With `phase_i`=0, hi1 swaps with hi2 and lo1 swaps with lo2: charge is 0110, slow decay is 0011, fast decay is 1001. The change is seen combinationally.
- R7: With `enable_i`=0, all gates are 0 in the same cycle. The period count keeps running, so the wrap comes at the same tick as it would with enable high.
- R8: `ref_code_o` is registered. It is the all-ones code one clock after `torque_i`=1 and floor((2^REF_W-1)*71/100) (181 for 8 bits) one clock after `torque_i`=0.
- R9: `ocp_i`=1 forces all gates to 0 in the same cycle and sets `fault_o` at the next clock. The fault then stays set, with gates 0, until standby or reset clears it.
- R10: While `standby_i`=1, the gates are 0 and `fault_o` is cleared at the next clock. After release the gates stay 0 until the first clock edge, which starts a new period in charge at count 0.
- R11: No gate combination ever turns on both switches of one leg: hi1 with lo1, or hi2 with lo2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick_i | input | 1 | One-cycle pulse per chopping-oscillator period |
| phase_i | input | 1 | Current direction: 1 forward, 0 reversed |
| enable_i | input | 1 | Gate enable; 0 blanks all gates |
| limit_i | input | 1 | Current-limit comparator flag |
| ocp_i | input | 1 | Over-current flag |
| standby_i | input | 1 | Standby request |
| torque_i | input | 1 | Setpoint select: 1 full scale, 0 reduced (71%) |
| hi1_o | output | 1 | High-side gate, leg 1 |
| hi2_o | output | 1 | High-side gate, leg 2 |
| lo1_o | output | 1 | Low-side gate, leg 1 |
| lo2_o | output | 1 | Low-side gate, leg 2 |
| ref_code_o | output | REF_W | Selected reference scale code |
| fault_o | output | 1 | Latched over-current fault |

## Verification
The phase, enable, over-current and standby inputs act on the gates combinationally, so they are checked in the same cycle they are applied. A mode change caused by a tick or by the limit flag, the torque code and the fault flag each pass through one register, so they are due after the next rising edge. The bench drives every input on a falling edge and samples the outputs on the following falling edge, which is one rising edge later. For the combinational cases it samples 1 ns after driving, before any rising edge occurs.

// File: rtl/chop_pkg.sv
// Shared types for the mixed-decay chopper.
// Assumes: the gate vector order {hi1,hi2,lo1,lo2} is used by every user.
package chop_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_CHARGE = 2'd1,
        MODE_SLOW   = 2'd2,
        MODE_FAST   = 2'd3
    } chop_mode_e;

    typedef struct packed {
        logic hi1;
        logic hi2;
        logic lo1;
        logic lo2;
    } gate_set_t;

    localparam gate_set_t GATES_OFF = '0;

endpackage

// File: rtl/chop_timer.sv
// Chopping-period counter: counts oscillator ticks modulo PERIOD_TICKS.
// Assumes: osc_tick_i is a single-cycle pulse synchronous to clk.
// restart_i forces the count to zero in the current cycle.
module chop_timer #(
    parameter int PERIOD_TICKS = 8,
    localparam int CNT_W = $clog2(PERIOD_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_nx_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             at_last;

    // Next count and period wrap detection.
    always_comb begin
        at_last = (cnt_q == LAST);
        wrap_o  = tick_i && at_last && !restart_i;
        if (restart_i)
            cnt_nx = '0;
        else if (tick_i)
            cnt_nx = at_last ? '0 : cnt_q + 1'b1;
        else
            cnt_nx = cnt_q;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nx;
    end

    assign cnt_nx_o = cnt_nx;

endmodule

// File: rtl/chop_sequencer.sv
// Mode sequencer: charge -> slow decay -> fast decay inside each period.
// Assumes: cnt_nx_i and wrap_i come from chop_timer; run_i low means
// standby or fault, and parks the sequencer in MODE_OFF.
module chop_sequencer
    import chop_pkg::*;
#(
    parameter int CNT_W    = 3,
    parameter int SLOW_END = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             limit_i,
    input  logic             wrap_i,
    input  logic [CNT_W-1:0] cnt_nx_i,
    output chop_mode_e       mode_o,
    output logic             restart_o
);

    localparam logic [CNT_W-1:0] SLOW_AT = CNT_W'(SLOW_END);

    chop_mode_e mode_q;
    chop_mode_e mode_d;
    logic       late;

    // Restart the period whenever parked or leaving park.
    assign restart_o = !run_i || (mode_q == MODE_OFF);
    assign late      = (cnt_nx_i >= SLOW_AT);

    // Next-mode selection.
    always_comb begin
        mode_d = mode_q;
        if (!run_i) begin
            mode_d = MODE_OFF;
        end else if (mode_q == MODE_OFF) begin
            mode_d = MODE_CHARGE;
        end else if (wrap_i) begin
            mode_d = MODE_CHARGE;
        end else begin
            case (mode_q)
                MODE_CHARGE: if (limit_i) mode_d = late ? MODE_FAST : MODE_SLOW;
                MODE_SLOW:   if (late)    mode_d = MODE_FAST;
                default:     mode_d = mode_q;
            endcase
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_OFF;
        else
            mode_q <= mode_d;
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/bridge_decoder.sv
// Maps mode and direction onto the four gate enables.
// Assumes: allow_i low must blank every gate with no clock delay.
module bridge_decoder
    import chop_pkg::*;
(
    input  chop_mode_e mode_i,
    input  logic       phase_i,
    input  logic       allow_i,
    output gate_set_t  gates_o
);

    gate_set_t fwd;

    // Forward-direction encoding of each mode.
    always_comb begin
        case (mode_i)
            MODE_CHARGE: fwd = '{hi1: 1'b1, hi2: 1'b0, lo1: 1'b0, lo2: 1'b1};
            MODE_SLOW:   fwd = '{hi1: 1'b0, hi2: 1'b0, lo1: 1'b1, lo2: 1'b1};
            MODE_FAST:   fwd = '{hi1: 1'b0, hi2: 1'b1, lo1: 1'b1, lo2: 1'b0};
            default:     fwd = GATES_OFF;
        endcase
    end

    // Leg swap for reverse direction, then blanking.
    always_comb begin
        if (!allow_i)
            gates_o = GATES_OFF;
        else if (phase_i)
            gates_o = fwd;
        else
            gates_o = '{hi1: fwd.hi2, hi2: fwd.hi1, lo1: fwd.lo2, lo2: fwd.lo1};
    end

endmodule

// File: rtl/fault_latch.sv
// Over-current fault latch; standby has priority and clears it.
// Assumes: ocp_i is already synchronous to clk.
module fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic ocp_i,
    output logic fault_o
);

    logic fault_q;

    // Set on over-current, clear on standby or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_q <= 1'b0;
        else if (standby_i)
            fault_q <= 1'b0;
        else if (ocp_i)
            fault_q <= 1'b1;
    end

    assign fault_o = fault_q;

endmodule

// File: rtl/ref_scale.sv
// Registered reference scale code: full scale or a reduced percentage.
// Assumes: REDUCED_PCT is between 1 and 100.
module ref_scale #(
    parameter int REF_W       = 8,
    parameter int REDUCED_PCT = 71
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             torque_i,
    output logic [REF_W-1:0] ref_o
);

    localparam int               FULL_INT = (1 << REF_W) - 1;
    localparam logic [REF_W-1:0] FULL_CODE = REF_W'(FULL_INT);
    localparam logic [REF_W-1:0] RED_CODE  = REF_W'((FULL_INT * REDUCED_PCT) / 100);

    logic [REF_W-1:0] ref_q;

    // Code register, full scale out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_q <= FULL_CODE;
        else
            ref_q <= torque_i ? FULL_CODE : RED_CODE;
    end

    assign ref_o = ref_q;

endmodule

// File: rtl/mixed_decay_chopper.sv
// Top: one H-bridge winding controller with mixed-decay chopping.
// Assumes: all inputs are synchronous to clk; analog sensing is external.
module mixed_decay_chopper
    import chop_pkg::*;
#(
    parameter int PERIOD_TICKS = 8,
    parameter int SLOW_END     = 6,
    parameter int REF_W        = 8,
    parameter int REDUCED_PCT  = 71
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick_i,
    input  logic             phase_i,
    input  logic             enable_i,
    input  logic             limit_i,
    input  logic             ocp_i,
    input  logic             standby_i,
    input  logic             torque_i,
    output logic             hi1_o,
    output logic             hi2_o,
    output logic             lo1_o,
    output logic             lo2_o,
    output logic [REF_W-1:0] ref_code_o,
    output logic             fault_o
);

    localparam int CNT_W = $clog2(PERIOD_TICKS);

    logic             fault_q;
    logic             run;
    logic             restart;
    logic             wrap;
    logic [CNT_W-1:0] cnt_nx;
    chop_mode_e       mode;
    gate_set_t        gates;

    // Chopping runs only when not in standby, fault or over-current.
    assign run = !standby_i && !fault_q && !ocp_i;

    chop_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (osc_tick_i),
        .restart_i (restart),
        .cnt_nx_o  (cnt_nx),
        .wrap_o    (wrap)
    );

    chop_sequencer #(.CNT_W(CNT_W), .SLOW_END(SLOW_END)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .limit_i   (limit_i),
        .wrap_i    (wrap),
        .cnt_nx_i  (cnt_nx),
        .mode_o    (mode),
        .restart_o (restart)
    );

    bridge_decoder u_dec (
        .mode_i  (mode),
        .phase_i (phase_i),
        .allow_i (run && enable_i),
        .gates_o (gates)
    );

    fault_latch u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_i (standby_i),
        .ocp_i     (ocp_i),
        .fault_o   (fault_q)
    );

    ref_scale #(.REF_W(REF_W), .REDUCED_PCT(REDUCED_PCT)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .torque_i (torque_i),
        .ref_o    (ref_code_o)
    );

    assign hi1_o   = gates.hi1;
    assign hi2_o   = gates.hi2;
    assign lo1_o   = gates.lo1;
    assign lo2_o   = gates.lo2;
    assign fault_o = fault_q;

endmodule

// File: rtl/chopper_checker.sv
// Port-level properties of mixed_decay_chopper, attached by bind.
// Assumes: reset is asserted from time zero.
module chopper_checker #(
    parameter int REF_W       = 8,
    parameter int REDUCED_PCT = 71
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_i,
    input logic             ocp_i,
    input logic             standby_i,
    input logic             torque_i,
    input logic             hi1_o,
    input logic             hi2_o,
    input logic             lo1_o,
    input logic             lo2_o,
    input logic [REF_W-1:0] ref_code_o,
    input logic             fault_o
);

    localparam int               FULL_INT  = (1 << REF_W) - 1;
    localparam logic [REF_W-1:0] FULL_CODE = REF_W'(FULL_INT);
    localparam logic [REF_W-1:0] RED_CODE  = REF_W'((FULL_INT * REDUCED_PCT) / 100);

    logic any_gate;
    assign any_gate = hi1_o | hi2_o | lo1_o | lo2_o;

    // R11
    leg_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi1_o && lo1_o) && !(hi2_o && lo2_o));

    // R7
    enable_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !any_gate);

    // R9
    ocp_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ocp_i && !standby_i) |=> fault_o);

    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !standby_i) |=> fault_o);

    // R9
    fault_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !any_gate);

    // R10
    standby_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |-> !any_gate);

    // R10
    standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> !fault_o);

    // R8
    torque_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        torque_i |=> (ref_code_o == FULL_CODE));

    // R8
    torque_reduced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !torque_i |=> (ref_code_o == RED_CODE));

endmodule

bind mixed_decay_chopper chopper_checker #(
    .REF_W       (REF_W),
    .REDUCED_PCT (REDUCED_PCT)
) u_chopper_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .ocp_i      (ocp_i),
    .standby_i  (standby_i),
    .torque_i   (torque_i),
    .hi1_o      (hi1_o),
    .hi2_o      (hi2_o),
    .lo1_o      (lo1_o),
    .lo2_o      (lo2_o),
    .ref_code_o (ref_code_o),
    .fault_o    (fault_o)
);

// File: tb/test_mixed_decay_chopper.sv
module test_mixed_decay_chopper;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int REF_W = 8;
    localparam logic [7:0] FULL = 8'd255;
    localparam logic [7:0] RED  = 8'd181;
    localparam int NVEC = 32;

    // {tick, limit, phase, enable, torque, gates{hi1,hi2,lo1,lo2}, ref_full, req}
    localparam logic [13:0] VEC [NVEC] = '{
        14'b1_0_1_1_1_1001_1_0101, // R5 tick, still charge
        14'b0_1_1_1_1_0011_1_0011, // R3 limit -> slow
        14'b1_0_1_1_1_0011_1_0011, // R3
        14'b1_0_1_1_1_0011_1_0011, // R3
        14'b1_0_1_1_1_0011_1_0011, // R3
        14'b1_0_1_1_1_0011_1_0011, // R3 count 5
        14'b1_0_1_1_1_0110_1_0100, // R4 count 6 -> fast
        14'b1_0_1_1_1_0110_1_0100, // R4 count 7
        14'b1_0_1_1_1_1001_1_0101, // R5 wrap -> charge
        14'b0_0_0_1_1_0110_1_0110, // R6 reversed charge
        14'b1_1_0_1_1_0011_1_0110, // R6 tick+limit -> slow
        14'b1_0_0_1_1_0011_1_0110, // R6
        14'b1_0_0_1_1_0011_1_0110, // R6
        14'b1_0_0_1_1_0011_1_0110, // R6
        14'b1_0_0_1_1_0011_1_0110, // R6 count 5
        14'b1_0_0_1_1_1001_1_0110, // R6 reversed fast
        14'b0_0_0_0_1_0000_1_0111, // R7 blank
        14'b1_0_0_0_1_0000_1_0111, // R7 count 7 while blanked
        14'b1_0_1_1_1_1001_1_0111, // R7 wrap at the usual tick
        14'b1_0_1_1_1_1001_1_0010, // R2 charge held, count 1
        14'b1_0_1_1_1_1001_1_0010, // R2
        14'b1_0_1_1_1_1001_1_0010, // R2
        14'b1_0_1_1_1_1001_1_0010, // R2
        14'b1_0_1_1_1_1001_1_0010, // R2 count 5
        14'b1_0_1_1_1_1001_1_0010, // R2 count 6, no limit
        14'b0_1_1_1_1_0110_1_0100, // R4 late limit -> fast
        14'b1_0_1_1_1_0110_1_0100, // R4
        14'b1_0_1_1_1_1001_1_0101, // R5 wrap
        14'b0_0_1_1_0_1001_0_1000, // R8 reduced code
        14'b0_0_1_1_1_1001_1_1000, // R8 full code
        14'b0_1_1_1_1_0011_1_0011, // R3 limit -> slow
        14'b1_1_1_1_1_0011_1_0011  // R3 repeated limit ignored
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick_i = 1'b0, phase_i = 1'b1, enable_i = 1'b1, limit_i = 1'b0;
    logic ocp_i = 1'b0, standby_i = 1'b0, torque_i = 1'b1;
    logic hi1_o, hi2_o, lo1_o, lo2_o, fault_o;
    logic [REF_W-1:0] ref_code_o;

    int checks = 0;
    int errors = 0;
    int shoot = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mixed_decay_chopper i_mixed_decay_chopper (
        .clk(clk), .rst_n(rst_n), .osc_tick_i(osc_tick_i), .phase_i(phase_i),
        .enable_i(enable_i), .limit_i(limit_i), .ocp_i(ocp_i),
        .standby_i(standby_i), .torque_i(torque_i),
        .hi1_o(hi1_o), .hi2_o(hi2_o), .lo1_o(lo1_o), .lo2_o(lo2_o),
        .ref_code_o(ref_code_o), .fault_o(fault_o)
    );

    function automatic logic [3:0] gates();
        return {hi1_o, hi2_o, lo1_o, lo2_o};
    endfunction

    function automatic string req_name(logic [3:0] r);
        case (r)
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(logic t, logic l, logic p, logic e, logic q);
        osc_tick_i = t; limit_i = l; phase_i = p; enable_i = e; torque_i = q;
    endtask

    // R11 shoot-through monitor on every falling edge
    always @(negedge clk)
        if (rst_n && ((hi1_o && lo1_o) || (hi2_o && lo2_o))) shoot++;

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 gates", 32'(gates()), 32'h0);
        check("R1 fault", 32'(fault_o), 32'h0);
        check("R1 ref", 32'(ref_code_o), 32'(FULL));
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 first period charge", 32'(gates()), 32'h9);

        foreach (VEC[i]) begin
            drive(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9]);
            @(negedge clk);
            check(req_name(VEC[i][3:0]), 32'(gates()), 32'(VEC[i][8:5]));
            if (VEC[i][3:0] == 4'd8)
                check("R8 ref", 32'(ref_code_o), VEC[i][4] ? 32'(FULL) : 32'(RED));
        end

        // R9 over-current: immediate blanking, then latched fault
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        ocp_i = 1'b1;
        #1;
        check("R9 immediate blank", 32'(gates()), 32'h0);
        @(negedge clk);
        check("R9 fault set", 32'(fault_o), 32'h1);
        ocp_i = 1'b0;
        for (int k = 0; k < 10; k++) begin
            drive(1'b1, k[0], 1'b1, 1'b1, 1'b1);
            @(negedge clk);
        end
        check("R9 fault held", 32'(fault_o), 32'h1);
        check("R9 gates held off", 32'(gates()), 32'h0);

        // R10 standby clears fault and blanks
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        standby_i = 1'b1;
        @(negedge clk);
        check("R10 fault cleared", 32'(fault_o), 32'h0);
        for (int k = 0; k < 5; k++) @(negedge clk);
        check("R10 standby blank", 32'(gates()), 32'h0);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        standby_i = 1'b0;
        #1;
        check("R10 off before edge", 32'(gates()), 32'h0);
        @(negedge clk);
        check("R10 charge after release", 32'(gates()), 32'h9);
        // R10 new period starts at count 0: six ticks reach fast via slow
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 5; k++) @(negedge clk);
        check("R10 count 5 still slow", 32'(gates()), 32'h3);
        @(negedge clk);
        check("R10 count 6 fast", 32'(gates()), 32'h6);

        // R9 reset also clears the fault
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        ocp_i = 1'b1;
        @(negedge clk);
        ocp_i = 1'b0;
        check("R9 fault set again", 32'(fault_o), 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears fault", 32'(fault_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11
        check("R11 shoot-through count", 32'(shoot), 32'h0);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule